// File: doc/BRIEF.md
# Run-Length Sample Encoder with Channel Group Packing

This block turns a stream of wide captured samples into the byte stream that a capture engine sends to its host. The sample word is split into equal byte-wide channel groups; a per-group disable mask removes whole groups from the stream, so each word shrinks to just the enabled groups. These are packed toward the low end and sent one byte at a time, lowest enabled group first.

With run-length mode on, repeated samples are folded into count words. A count word is marked by a 1 in the top bit of the packed word. Its other bits hold how many extra times the previous sample value repeated. To keep that marker free, the top bit of every packed sample word is forced to 0, so the channel in that position is given up.

Samples enter through a valid/ready handshake and bytes leave through another one. The mask and the mode bit are set between captures and are held steady during one. Each capture ends with a sample flagged as last.

Top module: `rle_pack_enc`

## Requirements
- R1: Setting grp_off[i] to 1 drops bits [8i+7:8i] from the output. The enabled groups are packed in ascending group order, and each word goes out as one byte per enabled group, lowest group first.
- R2: A grp_off value of 4'b1111 is handled as if only group 0 were enabled, so every word is one byte.
- R3: With rle_en low, each accepted sample produces exactly its packed word, bit for bit, and no other bytes.
- R4: With rle_en high, a sample word has its top packed bit (bit 8n-1 for n enabled groups) forced to 0. Values are compared for runs after that bit is cleared.
- R5: A count word has its top packed bit set to 1 and holds N in the remaining bits. It follows the sample word of its run and means that value appeared N more times (N+1 samples in total).
- R6: When the sample value changes, any pending count word of the old run goes out before the new sample word. A run of a single sample produces no count word.
- R7: When a run's count reaches the all-ones value of its field (2^(8n-1)-1), the count word goes out at once. The next sample then starts a new run with a sample word, even if its value is the same.
- R8: The sample flagged s_last closes its run and its pending count word goes out. The first sample after it always starts a new run with a sample word.
- R9: While b_ready is low, b_valid and b_data hold their values. s_ready stays low whenever accepting the sample would need a word slot that the byte stage cannot yet take.
- R10: After reset, no byte is offered (b_valid is 0) and the input is ready in non-run-length mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rle_en | input | 1 | Run-length mode enable |
| grp_off | input | 4 | Per-group disable mask, 1 drops the group |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample accepted when high with s_valid |
| s_data | input | 32 | Captured sample, group i in bits [8i+7:8i] |
| s_last | input | 1 | Marks the final sample of a capture |
| b_valid | output | 1 | Output byte valid |
| b_ready | input | 1 | Output byte accepted when high with b_valid |
| b_data | output | 8 | Output byte |

## Verification
Plain mode is run with all groups enabled, with a sparse mask and with an all-disabled mask. These patterns separate packing order from byte order and exercise the single-group fallback. Run-length mode gets sequences with mixed long and single-sample runs, which separate closing a run on a value change from leaving lone samples uncounted. It also gets samples with the top data bit set, which expose a missing flag clear. A 130-sample run in one-group mode crosses the count limit, and a capture that ends on a run and is followed by the same value shows whether s_last really closes the run. A reference model fills a scoreboard, while the output ready toggles in a fixed pseudo-random pattern and is also held low for a directed stall.

// File: rtl/rle_pack_pkg.sv
package rle_pack_pkg;

   typedef enum logic [2:0] {
      ACT_IDLE,
      ACT_PASS,
      ACT_REPEAT,
      ACT_COUNT,
      ACT_NEWRUN,
      ACT_FLUSH
   } rle_act_e;

endpackage

// File: rtl/rle_grp_packer.sv
module rle_grp_packer #(
   parameter int N_GRP = 4,
   parameter int GRP_W = 8,
   localparam int WORD_W = N_GRP * GRP_W,
   localparam int LEN_W  = $clog2(N_GRP + 1)
) (
   input  logic [WORD_W-1:0] raw,
   input  logic [N_GRP-1:0]  grp_off,
   output logic [WORD_W-1:0] packed_word,
   output logic [LEN_W-1:0]  packed_len
);

   logic             all_off;
   logic [N_GRP-1:0] grp_en;

   assign all_off = &grp_off;

   for (genvar g = 0; g < N_GRP; g++) begin : g_en
      if (g == 0) begin : g_first
         assign grp_en[g] = all_off | ~grp_off[g];
      end else begin : g_rest
         assign grp_en[g] = ~grp_off[g];
      end
   end

   always_comb begin
      int k;
      k = 0;
      packed_word = '0;
      for (int g = 0; g < N_GRP; g++) begin
         if (grp_en[g]) begin
            packed_word[k*GRP_W +: GRP_W] = raw[g*GRP_W +: GRP_W];
            k++;
         end
      end
      packed_len = LEN_W'(k);
   end

endmodule

// File: rtl/rle_run_tracker.sv
module rle_run_tracker
   import rle_pack_pkg::*;
#(
   parameter int N_GRP = 4,
   parameter int GRP_W = 8,
   localparam int WORD_W = N_GRP * GRP_W,
   localparam int LEN_W  = $clog2(N_GRP + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rle_en,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_word,
   input  logic [LEN_W-1:0]  in_len,
   input  logic              in_last,
   output logic              in_ready,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_word,
   output logic [LEN_W-1:0]  out_len,
   input  logic              out_ready
);

   localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

   logic              run_active;
   logic              flush_pend;
   logic [WORD_W-1:0] held;
   logic [LEN_W-1:0]  held_len;
   logic [WORD_W-1:0] cnt;
   logic [WORD_W-1:0] cnt_nxt;
   logic [WORD_W-1:0] in_top;
   logic [WORD_W-1:0] hold_top;
   logic [WORD_W-1:0] cnt_max;
   logic [WORD_W-1:0] sample_clean;
   logic              same;
   rle_act_e          act;

   assign in_top       = (in_len == '0)   ? ONE : ONE << (int'(in_len) * GRP_W - 1);
   assign hold_top     = (held_len == '0) ? ONE : ONE << (int'(held_len) * GRP_W - 1);
   assign cnt_max      = hold_top - ONE;
   assign sample_clean = in_word & ~in_top;
   assign same         = run_active && (held_len == in_len) && (sample_clean == held);
   assign cnt_nxt      = cnt + ONE;

   always_comb begin
      act       = ACT_IDLE;
      out_valid = 1'b0;
      out_word  = in_word;
      out_len   = in_len;
      in_ready  = 1'b0;
      if (!rle_en) begin
         act       = ACT_PASS;
         out_valid = in_valid;
         in_ready  = out_ready;
      end else if (flush_pend) begin
         act = ACT_FLUSH;
         if (cnt != '0) begin
            out_valid = 1'b1;
            out_word  = cnt | hold_top;
            out_len   = held_len;
         end
      end else if (in_valid) begin
         if (same) begin
            act      = ACT_REPEAT;
            in_ready = 1'b1;
         end else if (run_active && cnt != '0) begin
            act       = ACT_COUNT;
            out_valid = 1'b1;
            out_word  = cnt | hold_top;
            out_len   = held_len;
         end else begin
            act       = ACT_NEWRUN;
            out_valid = 1'b1;
            out_word  = sample_clean;
            in_ready  = out_ready;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !rle_en) begin
         run_active <= 1'b0;
         flush_pend <= 1'b0;
         cnt        <= '0;
         held       <= '0;
         held_len   <= '0;
      end else begin
         case (act)
            ACT_REPEAT: begin
               cnt <= cnt_nxt;
               if (cnt_nxt == cnt_max || in_last) flush_pend <= 1'b1;
            end
            ACT_COUNT: begin
               if (out_ready) cnt <= '0;
            end
            ACT_NEWRUN: begin
               if (out_ready) begin
                  held       <= sample_clean;
                  held_len   <= in_len;
                  run_active <= 1'b1;
                  cnt        <= '0;
                  if (in_last) flush_pend <= 1'b1;
               end
            end
            ACT_FLUSH: begin
               if (cnt == '0 || out_ready) begin
                  cnt        <= '0;
                  run_active <= 1'b0;
                  flush_pend <= 1'b0;
               end
            end
            default: ;
         endcase
      end
   end

   // R7: a run's count never passes the field's all-ones value
   p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rle_en && run_active) |-> (cnt <= cnt_max));

   // R4: the stored run value never carries the flag bit
   p_held_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rle_en && act == ACT_NEWRUN && out_ready) |=> ((held & hold_top) == '0));

   // R5: an absorbed repeat adds exactly one to the count
   p_repeat_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rle_en && act == ACT_REPEAT) |=> (cnt == $past(cnt) + ONE));

   // R8: a completed flush leaves no open run
   p_flush_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rle_en && flush_pend && (cnt == '0 || out_ready)) |=> !run_active);

endmodule

// File: rtl/rle_byte_ser.sv
module rle_byte_ser #(
   parameter int N_GRP = 4,
   parameter int GRP_W = 8,
   localparam int WORD_W = N_GRP * GRP_W,
   localparam int LEN_W  = $clog2(N_GRP + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              w_valid,
   input  logic [WORD_W-1:0] w_word,
   input  logic [LEN_W-1:0]  w_len,
   output logic              w_ready,
   output logic              b_valid,
   output logic [GRP_W-1:0]  b_data,
   input  logic              b_ready
);

   logic [WORD_W-1:0] sh;
   logic [LEN_W-1:0]  rem;

   assign b_valid = (rem != '0);
   assign b_data  = sh[GRP_W-1:0];
   assign w_ready = (rem == '0) || (rem == LEN_W'(1) && b_ready);

   generate
      if (N_GRP == 1) begin : g_one
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sh  <= '0;
               rem <= '0;
            end else if (w_valid && w_ready) begin
               sh  <= w_word;
               rem <= w_len;
            end else if (b_valid && b_ready) begin
               rem <= rem - LEN_W'(1);
            end
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sh  <= '0;
               rem <= '0;
            end else if (w_valid && w_ready) begin
               sh  <= w_word;
               rem <= w_len;
            end else if (b_valid && b_ready) begin
               sh  <= {{GRP_W{1'b0}}, sh[WORD_W-1:GRP_W]};
               rem <= rem - LEN_W'(1);
            end
         end
      end
   endgenerate

   // R9: an offered byte stays put until taken
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (b_valid && !b_ready) |=> (b_valid && $stable(b_data)));

   // R9: the last byte taken with nothing loaded empties the stage
   p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (b_valid && b_ready && rem == LEN_W'(1) && !w_valid) |=> !b_valid);

   // R1: a loaded word is one to N_GRP bytes long
   p_len_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (w_valid && w_ready) |=> (rem >= LEN_W'(1) && rem <= LEN_W'(N_GRP)));

endmodule

// File: rtl/rle_pack_enc.sv
module rle_pack_enc #(
   parameter int N_GRP = 4,
   parameter int GRP_W = 8,
   localparam int WORD_W = N_GRP * GRP_W,
   localparam int LEN_W  = $clog2(N_GRP + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rle_en,
   input  logic [N_GRP-1:0]  grp_off,
   input  logic              s_valid,
   output logic              s_ready,
   input  logic [WORD_W-1:0] s_data,
   input  logic              s_last,
   output logic              b_valid,
   input  logic              b_ready,
   output logic [GRP_W-1:0]  b_data
);

   if (N_GRP < 1) begin : g_bad_ngrp
      $error("rle_pack_enc: N_GRP must be at least 1");
   end
   if (GRP_W < 2) begin : g_bad_grpw
      $error("rle_pack_enc: GRP_W must be at least 2");
   end

   logic [WORD_W-1:0] pk_word;
   logic [LEN_W-1:0]  pk_len;
   logic              t_valid;
   logic [WORD_W-1:0] t_word;
   logic [LEN_W-1:0]  t_len;
   logic              t_ready;

   rle_grp_packer #(.N_GRP(N_GRP), .GRP_W(GRP_W)) u_pack (
      .raw         (s_data),
      .grp_off     (grp_off),
      .packed_word (pk_word),
      .packed_len  (pk_len)
   );

   rle_run_tracker #(.N_GRP(N_GRP), .GRP_W(GRP_W)) u_run (
      .clk       (clk),
      .rst_n     (rst_n),
      .rle_en    (rle_en),
      .in_valid  (s_valid),
      .in_word   (pk_word),
      .in_len    (pk_len),
      .in_last   (s_last),
      .in_ready  (s_ready),
      .out_valid (t_valid),
      .out_word  (t_word),
      .out_len   (t_len),
      .out_ready (t_ready)
   );

   rle_byte_ser #(.N_GRP(N_GRP), .GRP_W(GRP_W)) u_ser (
      .clk     (clk),
      .rst_n   (rst_n),
      .w_valid (t_valid),
      .w_word  (t_word),
      .w_len   (t_len),
      .w_ready (t_ready),
      .b_valid (b_valid),
      .b_data  (b_data),
      .b_ready (b_ready)
   );

   // R9: in plain mode no sample is taken while the byte stage is busy
   p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!rle_en && !t_ready) |-> !s_ready);

endmodule

// File: tb/tb_rle_pack_enc.sv
module tb_rle_pack_enc;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rle_en = 1'b0;
   logic [3:0]  grp_off = 4'b0000;
   logic        s_valid = 1'b0;
   logic        s_ready;
   logic [31:0] s_data = '0;
   logic        s_last = 1'b0;
   logic        b_valid;
   logic        b_ready;
   logic [7:0]  b_data;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   bit hold_low = 1'b0;
   bit bp_on = 1'b0;
   logic [7:0] lfsr = 8'hA5;
   string cur_req = "R10";

   logic [7:0] exp_q[$];
   string      req_q[$];

   bit          m_act = 1'b0;
   logic [31:0] m_held = '0;
   logic [31:0] m_cnt = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rle_pack_enc dut (
      .clk(clk), .rst_n(rst_n), .rle_en(rle_en), .grp_off(grp_off),
      .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
      .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic push_word(input logic [31:0] w, input int n);
      for (int i = 0; i < n; i++) begin
         exp_q.push_back(w[8*i +: 8]);
         req_q.push_back(cur_req);
      end
   endtask

   // Reference packing per R1/R2
   task automatic mdl_pack(input logic [31:0] d, input logic [3:0] off,
                           output logic [31:0] w, output int n);
      logic [3:0] en;
      en = (off == 4'hF) ? 4'b0001 : ~off;
      w = '0;
      n = 0;
      for (int g = 0; g < 4; g++) begin
         if (en[g]) begin
            w[8*n +: 8] = d[8*g +: 8];
            n++;
         end
      end
   endtask

   // Reference stream per R3..R8
   task automatic model(input logic [31:0] d, input bit last);
      logic [31:0] w, top, v, mx;
      int n;
      mdl_pack(d, grp_off, w, n);
      if (!rle_en) begin
         push_word(w, n);
      end else begin
         top = 32'd1 << (8*n - 1);
         v = w & ~top;
         mx = top - 1;
         if (m_act && v == m_held) begin
            m_cnt++;
            if (m_cnt == mx) begin
               push_word(m_cnt | top, n);
               m_act = 0;
               m_cnt = 0;
            end
         end else begin
            if (m_act && m_cnt != 0) push_word(m_cnt | top, n);
            push_word(v, n);
            m_held = v;
            m_cnt = 0;
            m_act = 1;
         end
         if (last) begin
            if (m_act && m_cnt != 0) push_word(m_cnt | top, n);
            m_act = 0;
            m_cnt = 0;
         end
      end
   endtask

   task automatic put(input logic [31:0] d, input bit last);
      model(d, last);
      @(negedge clk);
      s_valid = 1'b1;
      s_data = d;
      s_last = last;
      #1;
      while (!s_ready) begin
         @(negedge clk);
         #1;
      end
      @(negedge clk);
      s_valid = 1'b0;
      s_last = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic set_mode(input bit rle, input logic [3:0] off, input string req);
      drain();
      rle_en = rle;
      grp_off = off;
      cur_req = req;
      m_act = 0;
      m_cnt = 0;
      @(negedge clk);
   endtask

   // Scoreboard monitor
   initial begin
      b_ready = 1'b1;
      forever begin
         @(negedge clk);
         b_ready = hold_low ? 1'b0 : (bp_on ? lfsr[0] : 1'b1);
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         #1;
         if (rst_n && b_valid && b_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, cur_req, "unexpected byte", {24'd0, b_data}, 32'd0);
            end else begin
               logic [7:0] e;
               string r;
               e = exp_q.pop_front();
               r = req_q.pop_front();
               check(b_data == e, r, "byte", {24'd0, b_data}, {24'd0, e});
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R10: reset state
      check(b_valid == 1'b0, "R10", "b_valid after reset", {31'd0, b_valid}, 32'd0);
      check(s_ready == 1'b1, "R10", "s_ready after reset", {31'd0, s_ready}, 32'd1);

      // R9: stall with the output held off
      cur_req = "R9";
      hold_low = 1'b1;
      put(32'h44332211, 1'b0);
      model(32'h88776655, 1'b0);
      s_valid = 1'b1;
      s_data = 32'h88776655;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         #1;
         check(s_ready == 1'b0, "R9", "s_ready while busy", {31'd0, s_ready}, 32'd0);
         check(b_valid == 1'b1 && b_data == 8'h11, "R9", "held byte",
               {23'd0, b_valid, b_data}, {23'd0, 1'b1, 8'h11});
      end
      hold_low = 1'b0;
      #1;
      while (!s_ready) begin
         @(negedge clk);
         #1;
      end
      @(negedge clk);
      s_valid = 1'b0;

      bp_on = 1'b1;
      // R3 and R1: plain mode, all groups
      set_mode(1'b0, 4'b0000, "R3");
      for (int i = 0; i < 6; i++) put(32'hC0DE0000 + 32'(i * 32'h01010101), i == 5);
      // R1: sparse mask keeps groups 1 and 3
      set_mode(1'b0, 4'b0101, "R1");
      put(32'hAABBCCDD, 1'b0);
      put(32'h11223344, 1'b0);
      put(32'hF00DBEEF, 1'b1);
      // R2: all groups disabled
      set_mode(1'b0, 4'b1111, "R2");
      put(32'h12345678, 1'b0);
      put(32'h9ABCDEF0, 1'b1);

      // R6 and R5: runs with changes and single-sample runs
      set_mode(1'b1, 4'b0000, "R6");
      put(32'h01020304, 1'b0);
      put(32'h01020304, 1'b0);
      put(32'h01020304, 1'b0);
      put(32'h0A0B0C0D, 1'b0);
      put(32'h00000055, 1'b0);
      put(32'h00000055, 1'b0);
      put(32'h00000077, 1'b1);
      cur_req = "R5";
      put(32'h10203040, 1'b0);
      for (int i = 0; i < 9; i++) put(32'h10203040, 1'b0);
      put(32'h50607080, 1'b1);

      // R4: top data bit cleared, compare uses cleared value
      set_mode(1'b1, 4'b0011, "R4");
      put(32'h80120000, 1'b0);
      put(32'h00120000, 1'b0);
      put(32'hFFFF0000, 1'b0);
      put(32'h7FFF1234, 1'b1);

      // R7: count overflow with a one-byte word
      set_mode(1'b1, 4'b1110, "R7");
      for (int i = 0; i < 130; i++) put(32'h00000033, i == 129);

      // R8: end of capture closes run, next equal value starts afresh
      set_mode(1'b1, 4'b0000, "R8");
      put(32'h0000BEEF, 1'b0);
      put(32'h0000BEEF, 1'b0);
      put(32'h0000BEEF, 1'b1);
      put(32'h0000BEEF, 1'b0);
      put(32'h0000BEEF, 1'b1);

      drain();
      check(exp_q.size() == 0, "R8", "scoreboard empty", 32'(exp_q.size()), 32'd0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule